// File: doc/BRIEF.md
# Serial Frame and Bit-Rate Configuration Unit

This block holds the character-format and bit-rate settings for one channel of a multi-register serial controller. Software writes four byte-wide registers through a simple write strobe. The register at address 4 carries the parity, stop-bit and clock-mode fields. The register at address 5 carries the character length. Addresses 12 and 13 carry the low and high bytes of a 16-bit time constant. The block decodes these into frame parameters for a neighbouring transmitter or receiver.

It also produces two timing strobes. `base_tick` comes from a time-constant down-counter and fires once every (time constant + 2) clock cycles. `bit_tick` is that strobe divided again by 1, 16, 32 or 64, as the clock mode selects. Here the input clock is the reference clock.

The generator is a two-state machine. `GEN_LOAD` is entered from reset and always moves on to `GEN_RUN` after one cycle, loading the counter with time constant + 1. In `GEN_RUN` the counter steps down. When it reaches zero it emits `base_tick` and reloads, staying in `GEN_RUN`. The clock-mode selection is an enumeration: `CKM_X1`, `CKM_D16`, `CKM_D32`, `CKM_D64`.

Top module: `sfc_top`

## Requirements
- R1: After reset, all registers are zero. `par_mode` is 00, `two_stop` is 0 and `char_bits` is 5. Both `base_tick` and `bit_tick` then pulse every 2 cycles.
- R2: `par_mode` is encoded 00 = none, 01 = odd, 10 = even. Register 4 bit 0 enables parity. When parity is enabled, register 4 bit 1 set gives even and clear gives odd. With bit 0 clear the result is none, whatever bit 1 holds.
- R3: `two_stop` is 1 only when register 4 bits 3:2 equal 11. It changes only after a write to register 4.
- R4: `char_bits` follows register 5 bits 6:5: 00 gives 5, 01 gives 7, 10 gives 6 and 11 gives 8. The other bits of register 5 have no effect.
- R5: The time constant is register 12 (low byte) joined with register 13 (high byte).
- R6: `base_tick` is a single-cycle pulse with a period of exactly (time constant + 2) cycles.
- R7: Register 4 bits 7:6 select the clock mode: 00 = ÷1, 01 = ÷16, 10 = ÷32, 11 = ÷64. `bit_tick` fires on every Nth `base_tick` and never without one.
- R8: A time-constant write lets the current generator interval finish with the old value. The new value governs from the next reload onward.
- R9: A write to register 4 restarts the prescaler. No `bit_tick` appears in the write cycle, and a `base_tick` in that cycle is not counted. The next `bit_tick` therefore falls on the Nth following `base_tick`.
- R10: Writes to addresses other than 4, 5, 12 and 13 change neither the frame outputs nor the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| base_tick | output | 1 | Time-constant generator pulse |
| bit_tick | output | 1 | Bit-rate enable after the clock-mode divide |
| par_mode | output | 2 | Parity: 00 none, 01 odd, 10 even |
| two_stop | output | 1 | Two stop bits when 1 |
| char_bits | output | 4 | Character length, 5 to 8 |

## Verification
A clock-mode write can land in the same cycle as a generator pulse, and that pulse would otherwise complete a prescaler count. The bench waits until `bit_tick` is about to fire and drives a register-4 write in that very cycle. It then judges two things: that `bit_tick` stays low in that cycle, and that exactly 16 further `base_tick` pulses pass before the next `bit_tick`. A second collision puts a time-constant write in the middle of a running interval. The bench expects that interval to keep its old length and the one after it to take the new length.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ODD  = 2'b01,
        PAR_EVEN = 2'b10
    } par_mode_e;

    typedef enum logic [1:0] {
        CKM_X1  = 2'b00,
        CKM_D16 = 2'b01,
        CKM_D32 = 2'b10,
        CKM_D64 = 2'b11
    } ckmode_e;

    typedef enum logic {
        GEN_LOAD = 1'b0,
        GEN_RUN  = 1'b1
    } gen_state_e;

    typedef struct packed {
        par_mode_e  par;
        logic       two_stop;
        logic [3:0] bits;
        ckmode_e    ckm;
    } frame_cfg_t;
endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
    import sfc_pkg::*;
#(
    parameter int              TC_W     = 2 * DATA_W,
    parameter logic [ADDR_W-1:0] A_FMT  = 4'd4,
    parameter logic [ADDR_W-1:0] A_LEN  = 4'd5,
    parameter logic [ADDR_W-1:0] A_TCLO = 4'd12,
    parameter logic [ADDR_W-1:0] A_TCHI = 4'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output frame_cfg_t        cfg,
    output logic [TC_W-1:0]   tc,
    output logic              fmt_wr
);
    logic [1:0]        par_q;
    logic [1:0]        stop_q;
    logic [1:0]        ckm_q;
    logic [1:0]        len_q;
    logic [DATA_W-1:0] tclo_q;
    logic [DATA_W-1:0] tchi_q;

    assign fmt_wr = wr_en && (wr_addr == A_FMT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q  <= '0;
            stop_q <= '0;
            ckm_q  <= '0;
            len_q  <= '0;
            tclo_q <= '0;
            tchi_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_FMT) begin
                par_q  <= wr_data[1:0];
                stop_q <= wr_data[3:2];
                ckm_q  <= wr_data[7:6];
            end
            if (wr_addr == A_LEN)  len_q  <= wr_data[6:5];
            if (wr_addr == A_TCLO) tclo_q <= wr_data;
            if (wr_addr == A_TCHI) tchi_q <= wr_data;
        end
    end

    assign tc = TC_W'({tchi_q, tclo_q});

    always_comb begin
        cfg.par      = !par_q[0] ? PAR_NONE : (par_q[1] ? PAR_EVEN : PAR_ODD);
        cfg.two_stop = (stop_q == 2'b11);
        cfg.ckm      = ckmode_e'(ckm_q);
        unique case (len_q)
            2'b00:   cfg.bits = 4'd5;
            2'b01:   cfg.bits = 4'd7;
            2'b10:   cfg.bits = 4'd6;
            default: cfg.bits = 4'd8;
        endcase
    end
endmodule

// File: rtl/sfc_brg.sv
module sfc_brg
    import sfc_pkg::*;
#(
    parameter int TC_W = 16,
    localparam int CNT_W = TC_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TC_W-1:0] tc,
    output logic            tick
);
    gen_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    assign reload = CNT_W'(tc) + CNT_W'(1);

    // State register and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GEN_LOAD;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                GEN_LOAD: begin
                    cnt_q   <= reload;
                    state_q <= GEN_RUN;
                end
                GEN_RUN: begin
                    if (cnt_q == '0) cnt_q <= reload;
                    else             cnt_q <= cnt_q - CNT_W'(1);
                end
                default: state_q <= GEN_LOAD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tick = 1'b0;
        unique case (state_q)
            GEN_LOAD: tick = 1'b0;
            GEN_RUN:  tick = (cnt_q == '0);
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfc_presc.sv
module sfc_presc
    import sfc_pkg::*;
#(
    parameter int PS_W = 6
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    gen_tick,
    input  logic    restart,
    input  ckmode_e ckm,
    output logic    bit_tick
);
    logic [PS_W-1:0] pcnt_q;
    logic [PS_W-1:0] lim;

    always_comb begin
        unique case (ckm)
            CKM_X1:  lim = PS_W'(0);
            CKM_D16: lim = PS_W'(15);
            CKM_D32: lim = PS_W'(31);
            default: lim = PS_W'(63);
        endcase
    end

    assign bit_tick = gen_tick && !restart && (pcnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pcnt_q <= '0;
        else if (restart)  pcnt_q <= '0;
        else if (gen_tick) pcnt_q <= (pcnt_q == lim) ? '0 : pcnt_q + PS_W'(1);
    end
endmodule

// File: rtl/sfc_top.sv
module sfc_top
    import sfc_pkg::*;
#(
    parameter int TC_W = 2 * DATA_W,
    parameter int PS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              base_tick,
    output logic              bit_tick,
    output logic [1:0]        par_mode,
    output logic              two_stop,
    output logic [3:0]        char_bits
);
    frame_cfg_t      cfg;
    logic [TC_W-1:0] tc;
    logic            fmt_wr;

    sfc_regs #(.TC_W(TC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .tc(tc), .fmt_wr(fmt_wr)
    );

    sfc_brg #(.TC_W(TC_W)) u_brg (
        .clk(clk), .rst_n(rst_n), .tc(tc), .tick(base_tick)
    );

    sfc_presc #(.PS_W(PS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .gen_tick(base_tick), .restart(fmt_wr),
        .ckm(cfg.ckm), .bit_tick(bit_tick)
    );

    assign par_mode  = cfg.par;
    assign two_stop  = cfg.two_stop;
    assign char_bits = cfg.bits;
endmodule

// File: rtl/sfc_chk.sv
module sfc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic       base_tick,
    input logic       bit_tick,
    input logic [1:0] par_mode,
    input logic       two_stop,
    input logic [3:0] char_bits
);
    // R7
    bit_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> base_tick);

    // R2
    par_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_mode != 2'b11);

    // R4
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_bits >= 4'd5) && (char_bits <= 4'd8));

    // R9
    no_tick_on_fmt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 4'd4) |-> !bit_tick);

    // R6
    base_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_tick |=> !base_tick);

    // R3
    stop_only_on_fmt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($past(wr_en) && $past(wr_addr) == 4'd4) |-> $stable(two_stop));
endmodule

bind sfc_top sfc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .base_tick(base_tick), .bit_tick(bit_tick), .par_mode(par_mode),
    .two_stop(two_stop), .char_bits(char_bits)
);

// File: tb/sim_sfc_top.sv
`timescale 1ns/1ps
module sim_sfc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       base_tick, bit_tick, two_stop;
    logic [1:0] par_mode;
    logic [3:0] char_bits;
    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sfc_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .base_tick(base_tick), .bit_tick(bit_tick),
        .par_mode(par_mode), .two_stop(two_stop), .char_bits(char_bits)
    );

    // {reg4, reg5, par_mode, two_stop, char_bits}
    localparam int NV = 9;
    localparam logic [22:0] VEC [NV] = '{
        {8'h00, 8'h00, 2'b00, 1'b0, 4'd5},
        {8'h01, 8'h20, 2'b01, 1'b0, 4'd7},
        {8'h03, 8'h40, 2'b10, 1'b0, 4'd6},
        {8'h02, 8'h60, 2'b00, 1'b0, 4'd8},
        {8'h0C, 8'h9F, 2'b00, 1'b1, 4'd5},
        {8'h04, 8'hE0, 2'b00, 1'b0, 4'd8},
        {8'h08, 8'hA0, 2'b00, 1'b0, 4'd7},
        {8'h0F, 8'hC0, 2'b10, 1'b1, 4'd6},
        {8'h0D, 8'h7F, 2'b01, 1'b1, 4'd8}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick(input bit use_bit);
        int k = 0;
        @(negedge clk);
        while (((use_bit ? bit_tick : base_tick) == 1'b0) && k < 20000) begin
            @(negedge clk); k++;
        end
    endtask

    task automatic period(input bit use_bit, output int n);
        wait_tick(use_bit);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (((use_bit ? bit_tick : base_tick) == 1'b0) && n < 20000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, pm, cb, st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 par", par_mode, 0);
        check("R1 stop", two_stop, 0);
        check("R1 bits", char_bits, 5);
        period(1'b0, n); check("R1 base period", n, 2);
        period(1'b1, n); check("R1 bit period", n, 2);

        // R2 R3 R4 decode table
        for (int i = 0; i < NV; i++) begin
            wr(4'd4, VEC[i][22:15]);
            wr(4'd5, VEC[i][14:7]);
            check("R2 par", par_mode, int'(VEC[i][6:5]));
            check("R3 stop", two_stop, int'(VEC[i][4]));
            check("R4 bits", char_bits, int'(VEC[i][3:0]));
        end

        // R3 stop field holds across writes elsewhere
        wr(4'd5, 8'h00);
        wr(4'd12, 8'h00);
        check("R3 stop held", two_stop, 1);

        // R6 generator period
        wr(4'd4, 8'h00);
        wr(4'd12, 8'd3);
        period(1'b0, n);
        period(1'b0, n); check("R6 tc=3 period", n, 5);
        // R5 high byte from address 13
        wr(4'd12, 8'h00);
        wr(4'd13, 8'h01);
        period(1'b0, n);
        period(1'b0, n); check("R5 tc=0x100 period", n, 258);
        wr(4'd13, 8'h00);

        // R7 clock modes
        wr(4'd12, 8'd1);
        wr(4'd4, 8'h40);
        period(1'b1, n);
        period(1'b1, n); check("R7 div16 tc=1", n, 48);
        wr(4'd12, 8'd0);
        wr(4'd4, 8'h80);
        period(1'b1, n);
        period(1'b1, n); check("R7 div32 tc=0", n, 64);
        wr(4'd4, 8'hC0);
        period(1'b1, n);
        period(1'b1, n); check("R7 div64 tc=0", n, 128);

        // R10 unused addresses ignored
        pm = par_mode; cb = char_bits; st = two_stop;
        wr(4'd7, 8'hFF);
        wr(4'd6, 8'hFF);
        wr(4'd0, 8'hFF);
        check("R10 par", par_mode, pm);
        check("R10 bits", char_bits, cb);
        check("R10 stop", two_stop, st);
        period(1'b1, n);
        period(1'b1, n); check("R10 period", n, 128);

        // R8 mid-interval time-constant write
        wr(4'd4, 8'h00);
        wr(4'd12, 8'd9);
        wait_tick(1'b0);
        wait_tick(1'b0);
        wr_en = 1'b1; wr_addr = 4'd12; wr_data = 8'd2;
        @(negedge clk);
        wr_en = 1'b0;
        n = 1;
        while (!base_tick && n < 20000) begin
            @(negedge clk); n++;
        end
        check("R8 old interval", n, 11);
        n = 0;
        do begin
            @(negedge clk); n++;
        end while (!base_tick && n < 20000);
        check("R8 new interval", n, 4);

        // R9 register-4 write colliding with a completing count
        wr(4'd12, 8'd0);
        wr(4'd4, 8'h40);
        wait_tick(1'b1);
        wait_tick(1'b1);
        wr_en = 1'b1; wr_addr = 4'd4; wr_data = 8'h40;
        #1;
        check("R9 no tick in write cycle", bit_tick, 0);
        @(negedge clk);
        wr_en = 1'b0;
        n = 0;
        for (int k = 0; k < 20000; k++) begin
            if (base_tick) n++;
            if (bit_tick) break;
            @(negedge clk);
        end
        check("R9 restart count", n, 16);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule